// File: doc/BRIEF.md
# Serial Audio Output Formatter

This block turns a pair of 24-bit channel words, supplied by an upstream frame store, into a serial data stream with its bit clock and word clock. A frame lasts 64 bit-clock periods. The first half of the frame carries the left word and the second half carries the right word, each sent MSB first. In master mode the block divides its system clock to make the bit clock and the word clock. In slave mode it follows a bit clock and a word clock that come from outside, and it drives its own clock outputs low.

Configuration inputs set four things. The first is the word-clock level that marks the left half. The second is the bit-clock edge on which data changes. The third is the justification format: left-justified, one-bit-delayed (I2S style) or right-justified. The fourth is a trim field that shortens the right-justified word. The block samples the channel words and every configuration input once per frame, at the frame start, so a change made in the middle of a frame cannot corrupt the frame in progress. In master mode a sync pulse one bit clock long marks each frame start.

The whole block runs in the system-clock domain. The bit-clock edges become single-cycle events. In master mode these events come from a divider. In slave mode they come from synchronizers on the incoming clocks.

Top module: `serial_audio_out`

## Requirements
- R1: In master mode bck_o has a period of 2*HALF_DIV system clocks, and wck_o toggles only on falling bck_o edges, with 64 bck_o periods per wck_o period.
- R2: In slave mode (master_i=0), bck_o and wck_o are held low, and the frame timing follows bck_i and wck_i. A frame starts at the falling bck_i edge on which wck_i has just moved to the left-channel level.
- R3: With wck_pol_i=1 the word clock is high during the left half (slots 0..31) and low during the right half (slots 32..63). With wck_pol_i=0 the levels are reversed.
- R4: With late_edge_i=0, sdo_o changes on falling bit-clock edges. With late_edge_i=1, it changes on rising edges. In both cases the value for slot k is valid at the rising edge inside slot k.
- R5: fmt_i=00 (and 11) is left-justified: word bits 23..0 fill slots 0..23 of each half, and slots 24..31 are low.
- R6: fmt_i=10 is the delayed format: slot 0 of each half is low, word bits 23..0 fill slots 1..24, and slots 25..31 are low.
- R7: fmt_i=01 is right-justified. The word length is 24, 22, 20 or 18 bits for trim_i = 0, 1, 2 or 3. The LSB sits in slot 31 of the half, the lower word bits fill the slots before it, and all earlier slots are low.
- R8: In master mode sync_o is high for exactly one bit-clock period, slot 0 of every frame.
- R9: In slave mode sync_o stays low.
- R10: Channel words and configuration inputs are sampled at the frame start. Changes made after that have no effect on the current frame.
- R11: While rst_ni is low, sdo_o, sync_o, bck_o and wck_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1: generate clocks, 0: follow external clocks |
| wck_pol_i | input | 1 | Word-clock level that marks the left channel |
| late_edge_i | input | 1 | 0: data changes on falling bit-clock edge, 1: on rising edge |
| fmt_i | input | 2 | Justification format |
| trim_i | input | 2 | Right-justified length trim |
| left_i | input | 24 | Left channel word |
| right_i | input | 24 | Right channel word |
| bck_i | input | 1 | External bit clock (slave) |
| wck_i | input | 1 | External word clock (slave) |
| bck_o | output | 1 | Generated bit clock (master) |
| wck_o | output | 1 | Generated word clock (master) |
| sdo_o | output | 1 | Serial data |
| sync_o | output | 1 | Frame-start pulse (master) |

## Verification
The assertions assume that bck_i and wck_i are clean square waves when the block is a slave. They also assume each wck_i transition coincides with a falling bck_i edge, and that each bck_i level lasts longer than the synchronizer depth plus one system clock. The slave stimulus uses a bit clock of 16 system clocks and changes the word clock only together with a falling bit-clock edge. It samples data well after the synchronizer latency. Configuration changes in the stimulus occur mid-frame or with at least two frames of settling time, so every captured frame has one well-defined configuration.

// File: rtl/sao_pkg.sv
package sao_pkg;
  localparam int unsigned WORD_W      = 24;
  localparam int unsigned FRAME_SLOTS = 64;
  localparam int unsigned HALF_SLOTS  = FRAME_SLOTS / 2;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'b00,
    FMT_RJ  = 2'b01,
    FMT_DLY = 2'b10,
    FMT_ALT = 2'b11
  } fmt_e;

  typedef struct packed {
    logic       wck_pol;
    logic       late_edge;
    fmt_e       fmt;
    logic [1:0] trim;
  } cfg_t;

  // value of one slot within a half-frame
  function automatic logic pick_bit(input logic [WORD_W-1:0] w, input cfg_t c, input int pos);
    logic [WORD_W-1:0] sh;
    int idx;
    int len;
    idx = -1;
    len = int'(WORD_W) - 2 * int'(c.trim);
    case (c.fmt)
      FMT_RJ:  if (pos >= int'(HALF_SLOTS) - len && pos < int'(HALF_SLOTS)) idx = int'(HALF_SLOTS) - 1 - pos;
      FMT_DLY: if (pos >= 1 && pos <= int'(WORD_W)) idx = int'(WORD_W) - pos;
      default: if (pos < int'(WORD_W)) idx = int'(WORD_W) - 1 - pos;
    endcase
    if (idx < 0) return 1'b0;
    sh = w >> idx;
    return sh[0];
  endfunction
endpackage

// File: rtl/sao_clk_master.sv
module sao_clk_master #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic bck_o,
  output logic fall_o,
  output logic rise_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          bck_q;
  logic          tick;

  assign tick = (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bck_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      bck_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      bck_q <= ~bck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bck_o  = bck_q;
  assign fall_o = en_i & tick & bck_q;
  assign rise_o = en_i & tick & ~bck_q;

  AST_BCK_HALF_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && bck_q != $past(bck_q)) |-> $past(cnt_q) == CW'(HALF_DIV - 1)); // R1
endmodule

// File: rtl/sao_clk_slave.sv
module sao_clk_slave #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bck_i,
  input  logic wck_i,
  output logic fall_o,
  output logic rise_o,
  output logic wck_o
);
  logic [SYNC_STAGES:0]   bck_sh;
  logic [SYNC_STAGES-1:0] wck_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bck_sh <= '0;
      wck_sh <= '0;
    end else begin
      bck_sh <= {bck_sh[SYNC_STAGES-1:0], bck_i};
      wck_sh <= {wck_sh[SYNC_STAGES-2:0], wck_i};
    end
  end

  assign fall_o = bck_sh[SYNC_STAGES] & ~bck_sh[SYNC_STAGES-1];
  assign rise_o = ~bck_sh[SYNC_STAGES] & bck_sh[SYNC_STAGES-1];
  assign wck_o  = wck_sh[SYNC_STAGES-1];
endmodule

// File: rtl/sao_frame_ctr.sv
module sao_frame_ctr
  import sao_pkg::*;
#(
  localparam int unsigned SW = $clog2(FRAME_SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          master_i,
  input  logic          fall_i,
  input  logic          wck_in_i,
  input  logic          detect_pol_i,
  input  logic          lvl_pol_i,
  output logic [SW-1:0] slot_o,
  output logic [SW-1:0] next_slot_o,
  output logic          frame_start_o,
  output logic          wck_o
);
  logic [SW-1:0] slot_q, inc, nxt;
  logic          wck_prev_q, wck_q;

  always_comb begin
    inc = (slot_q == SW'(FRAME_SLOTS - 1)) ? '0 : slot_q + 1'b1;
    nxt = inc;
    if (!master_i && wck_in_i == detect_pol_i && wck_prev_q != detect_pol_i) nxt = '0;
  end

  assign frame_start_o = fall_i && (nxt == '0);
  assign slot_o        = slot_q;
  assign next_slot_o   = nxt;
  assign wck_o         = wck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q     <= '1;
      wck_prev_q <= 1'b0;
    end else if (fall_i) begin
      slot_q     <= nxt;
      wck_prev_q <= wck_in_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            wck_q <= 1'b0;
    else if (!master_i)     wck_q <= 1'b0;
    else if (fall_i)        wck_q <= nxt[SW-1] ? ~lvl_pol_i : lvl_pol_i;
  end

  AST_SLOT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && fall_i && slot_q == SW'(FRAME_SLOTS - 1)) |=> slot_q == '0); // R1
  AST_WCK_LEFT_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && frame_start_o) |=> (!master_i || wck_o == $past(lvl_pol_i))); // R3
endmodule

// File: rtl/sao_serializer.sv
module sao_serializer
  import sao_pkg::*;
#(
  localparam int unsigned SW = $clog2(FRAME_SLOTS),
  localparam int unsigned PW = SW - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic              frame_start_i,
  input  logic [SW-1:0]     slot_i,
  input  logic [SW-1:0]     next_slot_i,
  input  cfg_t              cfg_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  output cfg_t              cfg_eff_o,
  output logic              sdo_o,
  output logic              sync_o
);
  cfg_t              cfg_q;
  logic [WORD_W-1:0] l_q, r_q, l_eff, r_eff;
  logic              bit_f, bit_r, sdo_q, sync_q;

  // new frame uses the inputs directly, later slots the latched copy
  assign cfg_eff_o = frame_start_i ? cfg_i   : cfg_q;
  assign l_eff     = frame_start_i ? left_i  : l_q;
  assign r_eff     = frame_start_i ? right_i : r_q;

  assign bit_f = pick_bit(next_slot_i[SW-1] ? r_eff : l_eff, cfg_eff_o, int'(next_slot_i[PW-1:0]));
  assign bit_r = pick_bit(slot_i[SW-1] ? r_q : l_q, cfg_q, int'(slot_i[PW-1:0]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      l_q   <= '0;
      r_q   <= '0;
    end else if (frame_start_i) begin
      cfg_q <= cfg_i;
      l_q   <= left_i;
      r_q   <= right_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            sdo_q <= 1'b0;
    else if (fall_i && !cfg_eff_o.late_edge) sdo_q <= bit_f;
    else if (rise_i && cfg_q.late_edge)     sdo_q <= bit_r;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sync_q <= 1'b0;
    else if (!master_i) sync_q <= 1'b0;
    else if (fall_i)    sync_q <= frame_start_i;
  end

  assign sdo_o  = sdo_q;
  assign sync_o = sync_q;

  AST_LJ_TAIL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !frame_start_i && !cfg_q.late_edge && cfg_q.fmt == FMT_LJ &&
     int'(next_slot_i[PW-1:0]) >= int'(WORD_W)) |=> !sdo_o); // R5
  AST_DLY_LEAD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !frame_start_i && !cfg_q.late_edge && cfg_q.fmt == FMT_DLY &&
     next_slot_i[PW-1:0] == '0) |=> !sdo_o); // R6
  AST_SYNC_AT_SLOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> slot_i == '0); // R8
  AST_SYNC_SLAVE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> !sync_o); // R9
endmodule

// File: rtl/serial_audio_out.sv
module serial_audio_out
  import sao_pkg::*;
#(
  parameter int unsigned HALF_DIV    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              wck_pol_i,
  input  logic              late_edge_i,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        trim_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic              bck_i,
  input  logic              wck_i,
  output logic              bck_o,
  output logic              wck_o,
  output logic              sdo_o,
  output logic              sync_o
);
  localparam int unsigned SW = $clog2(FRAME_SLOTS);

  logic          m_fall, m_rise, s_fall, s_rise, s_wck;
  logic          fall, rise, frame_start;
  logic [SW-1:0] slot, next_slot;
  cfg_t          cfg_in, cfg_eff;

  assign cfg_in = '{wck_pol: wck_pol_i, late_edge: late_edge_i, fmt: fmt_e'(fmt_i), trim: trim_i};

  sao_clk_master #(.HALF_DIV(HALF_DIV)) i_clk_master (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (master_i),
    .bck_o (bck_o),
    .fall_o(m_fall),
    .rise_o(m_rise)
  );

  sao_clk_slave #(.SYNC_STAGES(SYNC_STAGES)) i_clk_slave (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bck_i (bck_i),
    .wck_i (wck_i),
    .fall_o(s_fall),
    .rise_o(s_rise),
    .wck_o (s_wck)
  );

  assign fall = master_i ? m_fall : s_fall;
  assign rise = master_i ? m_rise : s_rise;

  sao_frame_ctr i_frame_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .master_i     (master_i),
    .fall_i       (fall),
    .wck_in_i     (s_wck),
    .detect_pol_i (wck_pol_i),
    .lvl_pol_i    (cfg_eff.wck_pol),
    .slot_o       (slot),
    .next_slot_o  (next_slot),
    .frame_start_o(frame_start),
    .wck_o        (wck_o)
  );

  sao_serializer i_serializer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .master_i     (master_i),
    .fall_i       (fall),
    .rise_i       (rise),
    .frame_start_i(frame_start),
    .slot_i       (slot),
    .next_slot_i  (next_slot),
    .cfg_i        (cfg_in),
    .left_i       (left_i),
    .right_i      (right_i),
    .cfg_eff_o    (cfg_eff),
    .sdo_o        (sdo_o),
    .sync_o       (sync_o)
  );

  AST_EDGE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fall, rise})); // R4
  AST_SLAVE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> (!bck_o && !wck_o)); // R2
endmodule

// File: tb/test_serial_audio_out.sv
`timescale 1ns/1ps
module test_serial_audio_out;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        master_i = 1'b1;
  logic        wck_pol_i = 1'b0;
  logic        late_edge_i = 1'b0;
  logic [1:0]  fmt_i = 2'b00;
  logic [1:0]  trim_i = 2'b00;
  logic [23:0] left_i = '0;
  logic [23:0] right_i = '0;
  logic        bck_i = 1'b0;
  logic        wck_i = 1'b0;
  logic        bck_o, wck_o, sdo_o, sync_o;

  int checks = 0;
  int fails  = 0;

  // {pol, late_edge, fmt, trim, left, right}
  localparam logic [53:0] VEC [8] = '{
    {1'b1, 1'b0, 2'b00, 2'd0, 24'hA5C3F1, 24'h3C5A96},
    {1'b0, 1'b0, 2'b10, 2'd0, 24'h800001, 24'hF0F0F1},
    {1'b1, 1'b1, 2'b01, 2'd0, 24'h123456, 24'hABCDEF},
    {1'b0, 1'b0, 2'b01, 2'd1, 24'hFFFFFF, 24'hC00003},
    {1'b1, 1'b0, 2'b01, 2'd2, 24'h9A5F3C, 24'h6B2D81},
    {1'b0, 1'b1, 2'b01, 2'd3, 24'hFFFFFF, 24'h2AAAAB},
    {1'b1, 1'b1, 2'b10, 2'd0, 24'h5A5A5B, 24'hC3C3C4},
    {1'b0, 1'b0, 2'b11, 2'd0, 24'hE1D2C3, 24'h0B1C2D}
  };

  serial_audio_out i_serial_audio_out (
    .clk_i, .rst_ni, .master_i, .wck_pol_i, .late_edge_i, .fmt_i, .trim_i,
    .left_i, .right_i, .bck_i, .wck_i, .bck_o, .wck_o, .sdo_o, .sync_o
  );

  always #5 clk_i = ~clk_i;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // bit 31 = slot 0 of the half
  function automatic logic [31:0] exp_half(input logic [23:0] w, input logic [1:0] f, input logic [1:0] t);
    case (f)
      2'b10:   return {1'b0, w, 7'b0};
      2'b01:   return {8'b0, w} & (32'hFFFF_FFFF >> (8 + 2 * int'(t)));
      default: return {w, 8'b0};
    endcase
  endfunction

  // master capture: bit 63 = slot 0
  task automatic capture(input logic pol, input logic change,
                         output logic [63:0] dat, output logic [63:0] fdat,
                         output logic [63:0] wl, output logic [63:0] sy);
    logic prev;
    @(negedge bck_o); #1;
    prev = wck_o;
    forever begin
      @(negedge bck_o); #1;
      if (wck_o == pol && prev != pol) break;
      prev = wck_o;
    end
    for (int k = 0; k < 64; k++) begin
      if (k > 0) begin @(negedge bck_o); #1; end
      wl[63-k]   = wck_o;
      fdat[63-k] = sdo_o;
      if (change && k == 0) begin
        left_i  = ~left_i;
        right_i = ~right_i;
        fmt_i   = 2'b01;
        trim_i  = 2'd2;
      end
      @(posedge bck_o); #1;
      dat[63-k] = sdo_o;
      sy[63-k]  = sync_o;
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog R1 act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] dat, fdat, wl, sy, expd, sd;
    logic        anysync, anyclk;
    string       req;

    repeat (5) @(posedge clk_i);
    #2;
    check("R11 reset outputs", {60'b0, sdo_o, sync_o, bck_o, wck_o}, 64'h0);
    rst_ni = 1'b1;

    for (int v = 0; v < 8; v++) begin
      wck_pol_i   = VEC[v][53];
      late_edge_i = VEC[v][52];
      fmt_i       = VEC[v][51:50];
      trim_i      = VEC[v][49:48];
      left_i      = VEC[v][47:24];
      right_i     = VEC[v][23:0];
      repeat (600) @(posedge clk_i);
      #1;
      capture(VEC[v][53], 1'b0, dat, fdat, wl, sy);
      expd = {exp_half(VEC[v][47:24], VEC[v][51:50], VEC[v][49:48]),
              exp_half(VEC[v][23:0],  VEC[v][51:50], VEC[v][49:48])};
      req = (VEC[v][51:50] == 2'b01) ? "R7 data" : (VEC[v][51:50] == 2'b10) ? "R6 data" : "R5 data";
      check(req, dat, expd);
      check("R3 R1 word clock", wl, {{32{VEC[v][53]}}, {32{~VEC[v][53]}}});
      check("R8 sync", sy, 64'h8000_0000_0000_0000);
      if (VEC[v][52]) check("R4 late edge", {1'b0, fdat[62:0]}, {1'b0, dat[63:1]});
      else            check("R4 early edge", fdat, dat);
    end

    // R10: mid-frame change keeps current frame, applies on next
    wck_pol_i = 1'b1; late_edge_i = 1'b0; fmt_i = 2'b00; trim_i = 2'd0;
    left_i = 24'hA5C3F1; right_i = 24'h0F0F0F;
    repeat (600) @(posedge clk_i);
    #1;
    capture(1'b1, 1'b1, dat, fdat, wl, sy);
    check("R10 frame unchanged", dat, {exp_half(24'hA5C3F1, 2'b00, 2'd0), exp_half(24'h0F0F0F, 2'b00, 2'd0)});
    capture(1'b1, 1'b0, dat, fdat, wl, sy);
    check("R10 next frame updated", dat, {exp_half(24'h5A3C0E, 2'b01, 2'd2), exp_half(24'hF0F0F0, 2'b01, 2'd2)});

    // slave mode
    wck_pol_i = 1'b0; late_edge_i = 1'b0; fmt_i = 2'b10; trim_i = 2'd0;
    left_i = 24'hC0FFEE; right_i = 24'h135799;
    wck_i = 1'b1; bck_i = 1'b1;
    master_i = 1'b0;
    repeat (20) @(posedge clk_i);
    anysync = 1'b0; anyclk = 1'b0; sd = '0;
    for (int f = 0; f < 3; f++) begin
      for (int k = 0; k < 64; k++) begin
        bck_i = 1'b0;
        wck_i = (k < 32) ? 1'b0 : 1'b1;
        #80;
        bck_i = 1'b1;
        #60;
        if (f == 2) sd[63-k] = sdo_o;
        anysync = anysync | sync_o;
        anyclk  = anyclk | bck_o | wck_o;
        #20;
      end
    end
    check("R6 R2 slave data", sd, {exp_half(24'hC0FFEE, 2'b10, 2'd0), exp_half(24'h135799, 2'b10, 2'd0)});
    check("R9 slave sync low", {63'b0, anysync}, 64'h0);
    check("R2 slave clocks low", {63'b0, anyclk}, 64'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule